// File: doc/BRIEF.md
# Receive FIFO Idle Time-out Detector

This block sits beside a UART receive FIFO and raises a time-out request when characters have been left in the FIFO with no traffic for a set number of character times. It covers the case where the FIFO holds fewer characters than the trigger level, so the data-available interrupt never fires and the CPU would otherwise not learn that bytes are waiting. The request feeds the UART interrupt arbiter. It is gated by the same enable that gates the data-available request.

The caller supplies four inputs: a FIFO-mode flag, a FIFO non-empty flag, single-cycle pulses for each push and each pop, and a single-cycle pulse once per character time. The character-time pulse comes from the baud and frame-length logic. A saturating counter advances on each character-time pulse while the FIFO holds data and no push or pop occurs. Any push or pop clears it, and so does an empty FIFO or leaving FIFO mode. Once the counter reaches the limit, the time-out stays high until one of those clearing events.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After a synchronous active-low reset, `tmo_flag` and `tmo_req` are both 0.
- R2: With `fifo_mode`=1 and `fifo_nonempty`=1 held, and with no push or pop, `tmo_flag` goes to 1 in the cycle after the clock edge that samples the fourth `char_tick` pulse. Before that edge it stays 0.
- R3: The counter advances only on clock edges where `char_tick` is 1. Idle cycles without a tick, of any number, neither advance nor reset it.
- R4: A cycle with `rx_push`=1 or `rx_pop`=1 resets the count to zero and drops `tmo_flag` in the following cycle. A push or pop wins over a `char_tick` pulse in the same cycle.
- R5: A cycle with `fifo_nonempty`=0 resets the count to zero and drops `tmo_flag` in the following cycle.
- R6: Once `tmo_flag` is 1, further `char_tick` pulses keep it at 1 (the count saturates). It stays 1 until a push, a pop, an empty FIFO or leaving FIFO mode.
- R7: A cycle with `fifo_mode`=0 resets the count to zero. While `fifo_mode` stays 0, `tmo_flag` stays 0 whatever the ticks are.
- R8: `tmo_req` equals `tmo_flag` AND `rx_avail_en` in the same cycle. `rx_avail_en` has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | 1 = FIFO mode, time-out detection active |
| fifo_nonempty | input | 1 | 1 = receive FIFO holds at least one character |
| rx_push | input | 1 | One-cycle pulse per character written into the FIFO |
| rx_pop | input | 1 | One-cycle pulse per character read from the FIFO |
| char_tick | input | 1 | One-cycle pulse once per character time |
| rx_avail_en | input | 1 | Data-available interrupt enable, also gates the time-out request |
| tmo_flag | output | 1 | Ungated time-out condition |
| tmo_req | output | 1 | Time-out request to the interrupt arbiter |

## Verification
The main sweep sends every tick count from zero to six, with zero to three idle cycles between ticks. This separates the exact threshold edge from off-by-one counts, and tick-driven counting from cycle-driven counting. Pushes and pops are placed after each partial count from one to four, and one push lands together with a tick. These cases show whether an access truly restarts the interval or only masks the output. Separate runs empty the FIFO and leave FIFO mode mid-count and after saturation, and toggle the enable, so that each clearing path and the output gating are seen apart from the others.

// File: rtl/rto_pkg.sv
// Package: shared types for the receive FIFO time-out detector.
// Assumes: nothing beyond IEEE 1800-2017.
package rto_pkg;

    // What the character-time counter does on the next clock edge.
    typedef enum logic [1:0] {
        STEP_HOLD    = 2'd0,
        STEP_CLEAR   = 2'd1,
        STEP_ADVANCE = 2'd2
    } rto_step_e;

endpackage

// File: rtl/rto_step_decode.sv
// Module: rto_step_decode
// Decides each cycle whether the idle counter holds, clears or advances.
// Assumes: push, pop and tick are single-cycle pulses; clearing events
// (mode off, FIFO empty, any access) take priority over a tick.
module rto_step_decode
    import rto_pkg::*;
(
    input  logic      fifo_mode,
    input  logic      fifo_nonempty,
    input  logic      rx_push,
    input  logic      rx_pop,
    input  logic      char_tick,
    output rto_step_e step
);

    logic clear_now;

    // Purpose: collect every condition that restarts the idle interval.
    always_comb begin
        clear_now = !fifo_mode || !fifo_nonempty || rx_push || rx_pop;
    end

    // Purpose: pick the counter action, clearing ahead of advancing.
    always_comb begin
        if (clear_now) begin
            step = STEP_CLEAR;
        end else if (char_tick) begin
            step = STEP_ADVANCE;
        end else begin
            step = STEP_HOLD;
        end
    end

endmodule

// File: rtl/rto_char_counter.sv
// Module: rto_char_counter
// Saturating count of idle character times; flags when the limit is reached.
// Assumes: LIMIT >= 1; step comes from rto_step_decode.
module rto_char_counter
    import rto_pkg::*;
#(
    parameter int LIMIT = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  rto_step_e step,
    output logic      at_limit
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] count_q;

    // Purpose: apply the decoded step, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (step)
                STEP_CLEAR:   count_q <= '0;
                STEP_ADVANCE: if (count_q != LIMIT_V) count_q <= count_q + 1'b1;
                default:      count_q <= count_q;
            endcase
        end
    end

    // Purpose: report the saturated state.
    always_comb begin
        at_limit = (count_q == LIMIT_V);
    end

endmodule

// File: rtl/rto_req_gate.sv
// Module: rto_req_gate
// Drives the ungated flag and the enable-gated request to the arbiter.
// Assumes: the enable is the same one that gates data-available requests.
module rto_req_gate (
    input  logic at_limit,
    input  logic rx_avail_en,
    output logic tmo_flag,
    output logic tmo_req
);

    // Purpose: expose the condition and its gated request.
    always_comb begin
        tmo_flag = at_limit;
        tmo_req  = at_limit && rx_avail_en;
    end

endmodule

// File: rtl/rx_fifo_timeout.sv
// Module: rx_fifo_timeout (top)
// Raises a time-out when the receive FIFO holds data and sees no push or
// pop for IDLE_CHARS character times, in FIFO mode only.
// Assumes: char_tick is a one-cycle pulse per character time from the caller.
module rx_fifo_timeout
    import rto_pkg::*;
#(
    parameter int IDLE_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_mode,
    input  logic fifo_nonempty,
    input  logic rx_push,
    input  logic rx_pop,
    input  logic char_tick,
    input  logic rx_avail_en,
    output logic tmo_flag,
    output logic tmo_req
);

    rto_step_e step;
    logic      at_limit;

    rto_step_decode u_dec (
        .fifo_mode     (fifo_mode),
        .fifo_nonempty (fifo_nonempty),
        .rx_push       (rx_push),
        .rx_pop        (rx_pop),
        .char_tick     (char_tick),
        .step          (step)
    );

    rto_char_counter #(.LIMIT(IDLE_CHARS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .at_limit (at_limit)
    );

    rto_req_gate u_gate (
        .at_limit    (at_limit),
        .rx_avail_en (rx_avail_en),
        .tmo_flag    (tmo_flag),
        .tmo_req     (tmo_req)
    );

endmodule

// File: rtl/rto_checker.sv
// Module: rto_checker
// Temporal properties of rx_fifo_timeout, bound to the top module.
// Assumes: synchronous active-low reset on rst_n.
module rto_checker (
    input logic clk,
    input logic rst_n,
    input logic fifo_mode,
    input logic fifo_nonempty,
    input logic rx_push,
    input logic rx_pop,
    input logic char_tick,
    input logic rx_avail_en,
    input logic tmo_flag,
    input logic tmo_req
);

    // R1: a reset cycle leaves the flag low afterwards
    a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !tmo_flag);

    // R2: the flag can only rise right after a sampled tick
    a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(char_tick));

    // R4: any access drops the flag on the next cycle
    a_r4_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push || rx_pop) |=> !tmo_flag);

    // R5: an empty FIFO drops the flag on the next cycle
    a_r5_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !tmo_flag);

    // R6: the flag holds while nothing clears it
    a_r6_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && fifo_mode && fifo_nonempty && !rx_push && !rx_pop) |=> tmo_flag);

    // R7: outside FIFO mode the flag is low on the next cycle
    a_r7_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |=> !tmo_flag);

    // R8: request only with enable and flag
    a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req |-> (rx_avail_en && tmo_flag));

endmodule

bind rx_fifo_timeout rto_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_mode     (fifo_mode),
    .fifo_nonempty (fifo_nonempty),
    .rx_push       (rx_push),
    .rx_pop        (rx_pop),
    .char_tick     (char_tick),
    .rx_avail_en   (rx_avail_en),
    .tmo_flag      (tmo_flag),
    .tmo_req       (tmo_req)
);

// File: tb/sim_rx_fifo_timeout.sv
module sim_rx_fifo_timeout;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_mode = 1'b0;
    logic fifo_nonempty = 1'b0;
    logic rx_push = 1'b0;
    logic rx_pop = 1'b0;
    logic char_tick = 1'b0;
    logic rx_avail_en = 1'b0;
    logic tmo_flag;
    logic tmo_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rx_fifo_timeout #(.IDLE_CHARS(4)) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .fifo_nonempty(fifo_nonempty), .rx_push(rx_push), .rx_pop(rx_pop),
        .char_tick(char_tick), .rx_avail_en(rx_avail_en),
        .tmo_flag(tmo_flag), .tmo_req(tmo_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // one cycle with the given pulses, ending at the next negedge
    task automatic cyc(input logic tk, input logic ps, input logic pp);
        char_tick = tk; rx_push = ps; rx_pop = pp;
        @(negedge clk);
        char_tick = 0; rx_push = 0; rx_pop = 0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, 0);
            for (int g = 0; g < gap; g++) cyc(0, 0, 0);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1 flag", tmo_flag, 1'b0);
        chk("R1 req", tmo_req, 1'b0);
        rst_n = 1;
        fifo_mode = 1; fifo_nonempty = 1;

        // R2 R3 R8: threshold sweep over tick count and idle gap
        for (int gap = 0; gap < 4; gap++) begin
            for (int n = 0; n < 7; n++) begin
                rx_avail_en = gap[0];
                cyc(0, 1, 0);
                ticks(n, gap);
                chk("R2/R3 flag", tmo_flag, n >= 4);
                chk("R8 req", tmo_req, (n >= 4) && gap[0]);
            end
        end

        // R6: saturation holds over many ticks and idle cycles
        rx_avail_en = 1;
        cyc(0, 1, 0);
        ticks(10, 2);
        chk("R6 saturated", tmo_flag, 1'b1);
        rx_avail_en = 0;
        cyc(0, 0, 0);
        chk("R8 enable off", tmo_req, 1'b0);
        chk("R8 flag unaffected", tmo_flag, 1'b1);
        rx_avail_en = 1;

        // R4: access after k ticks restarts the full interval
        for (int k = 1; k < 5; k++) begin
            cyc(0, 1, 0);
            ticks(k, 1);
            cyc(0, k[0], !k[0]);
            chk("R4 cleared by access", tmo_flag, 1'b0);
            ticks(3, 0);
            chk("R4 restart short", tmo_flag, 1'b0);
            ticks(1, 0);
            chk("R4 restart full", tmo_flag, 1'b1);
        end

        // R4: push together with a tick wins
        cyc(1, 1, 0);
        chk("R4 push beats tick", tmo_flag, 1'b0);
        ticks(3, 0);
        chk("R4 tick not counted", tmo_flag, 1'b0);
        ticks(1, 0);
        chk("R4 count after push", tmo_flag, 1'b1);

        // R5: empty FIFO clears, ticks while empty do not count
        fifo_nonempty = 0;
        cyc(0, 0, 0);
        chk("R5 empty clears", tmo_flag, 1'b0);
        ticks(5, 0);
        chk("R5 empty no count", tmo_flag, 1'b0);
        fifo_nonempty = 1;
        ticks(2, 0);
        fifo_nonempty = 0;
        cyc(0, 0, 0);
        fifo_nonempty = 1;
        ticks(3, 0);
        chk("R5 mid-count reset", tmo_flag, 1'b0);
        ticks(1, 0);
        chk("R5 full after refill", tmo_flag, 1'b1);

        // R7: leaving FIFO mode clears and blocks counting
        fifo_mode = 0;
        cyc(0, 0, 0);
        chk("R7 mode off clears", tmo_flag, 1'b0);
        chk("R7 mode off req", tmo_req, 1'b0);
        ticks(6, 1);
        chk("R7 no count in mode off", tmo_flag, 1'b0);
        fifo_mode = 1;
        ticks(3, 0);
        chk("R7 restart short", tmo_flag, 1'b0);
        ticks(1, 0);
        chk("R7 restart full", tmo_flag, 1'b1);

        // R1: reset mid-saturation
        rst_n = 0;
        cyc(0, 0, 0);
        rst_n = 1;
        chk("R1 reset clears", tmo_flag, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule